// File: doc/BRIEF.md
# Half-Duplex Clocked Serial Port

This block is a small synchronous serial port that a host drives through read and write strobes on two addresses. A single 8-bit data register does both jobs: it is loaded with the byte to send, and it collects the byte being received. Only one direction runs at a time, so the port is half-duplex. There is no buffering. A host write to the data register in the middle of a transfer replaces the bits that have not yet been shifted. A host read in the middle of a transfer returns a partly shifted value.

The control register has four groups of fields:
- bits [2:0] pick the bit-clock rate;
- bit 4 starts a transmit and bit 5 starts a receive;
- bit 6 enables the interrupt;
- bit 7 is a read-only end flag.

A speed code from 0 to 6 makes the block generate the bit clock itself, at the system clock divided by 20·2^n. Code 7 hands timing to an external bit clock, which is synchronised before use. Data leaves least significant bit first. The output bit changes on each falling bit-clock edge, and the input is sampled on each rising edge. After the eighth rising edge the start bit clears itself and the end flag sets. The interrupt output stays high while the end flag and the interrupt enable are both set.

Top module: `hdx_serial_port`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the data register (address 1) reads 0x00, `sclk_out` and `sdo` are high, and `irq` is low.
- R2: Transmit sends the data register on `sdo` least significant bit first. `sdo` changes only on a falling edge of the bit clock, so it is stable at each rising edge. The vacated bits fill with zero, so the data register reads 0x00 after a full transmit.
- R3: Receive samples `sdi` on each rising bit-clock edge, least significant bit first. Each new bit enters the register at bit 7, and after eight bits the data register holds the received byte.
- R4: The start bit (control bit 4 for transmit, bit 5 for receive) clears itself after the 8th bit, and end flag bit 7 then sets. A control write that changes bits 4 or 5 while a transfer runs has no effect on them.
- R5: A host read or write of the data register clears the end flag. A read of the control register leaves it unchanged.
- R6: `irq` is high exactly while the end flag and the interrupt enable (control bit 6) are both set.
- R7: For speed code n from 0 to 6, the internal bit clock on `sclk_out` has a period of 20·2^n system clocks. `sclk_out` rests high when no transfer runs.
- R8: With speed code 7, the transfer is timed by edges of `sclk_in`, and `sclk_out` stays high.
- R9: A control write that sets bits 4 and 5 together starts a transmit. Bit 5 is dropped and reads back 0.
- R10: A data-register write during a transmit replaces the remaining shift contents at once. The following bits on `sdo` come from the new value, and the bit count carries on so the transfer still ends after 8 bits.
- R11: A data-register read during a receive returns the partly shifted contents: the bits received so far sit in the top of the register, above the shifted-down older bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 1 | 0 selects control, 1 selects data |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data of the addressed register |
| irq | output | 1 | End-of-transfer interrupt |
| sclk_out | output | 1 | Generated bit clock, idles high |
| sclk_in | input | 1 | External bit clock (speed code 7) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest situation to reach from the ports is a host access landing inside a particular bit window of a running transfer. This covers an overwrite between the fourth and fifth bit, a partial read after exactly four received bits, and a control write mid-transmit. The bench reaches these windows by following `sclk_out` itself. It counts rising edges, then makes its host access in the half-period before the next falling edge, where the effect on the following bits can be predicted exactly. The external-clock case is reached by the bench generating `sclk_in` slowly, with `sdi` changed while that clock is low.

// File: rtl/hdx_serial_pkg.sv
package hdx_serial_pkg;
   localparam int SPD_W   = 3;
   localparam int CTRL_W  = 8;
   localparam int BIT_TX  = 4;
   localparam int BIT_RX  = 5;
   localparam int BIT_IE  = 6;
   localparam logic [SPD_W-1:0] SPD_EXT = '1;

   typedef struct packed {
      logic             end_f;
      logic             irq_en;
      logic             rx_go;
      logic             tx_go;
      logic             rsv;
      logic [SPD_W-1:0] spd;
   } ctrl_t;
endpackage

// File: rtl/hdx_clk_gen.sv
module hdx_clk_gen
   import hdx_serial_pkg::*;
#(
   parameter int DIV_BASE  = 20,
   parameter int CLK_SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SPD_W-1:0] speed,
   input  logic             sclk_ext,
   output logic             sclk_int,
   output logic             fall_p,
   output logic             rise_p
);
   localparam int HALF_BASE = DIV_BASE / 2;
   localparam int MAX_HALF  = HALF_BASE << ((1 << SPD_W) - 2);
   localparam int CNT_W     = $clog2(MAX_HALF + 1);

   if (DIV_BASE < 2 || (DIV_BASE % 2) != 0) begin : g_bad_div
      $error("DIV_BASE must be even and at least 2");
   end
   if (CLK_SYNC < 2) begin : g_bad_sync
      $error("CLK_SYNC must be at least 2");
   end

   logic             ext_mode;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_lim;
   logic             sclk_q;
   logic             int_tick;
   logic [CLK_SYNC-1:0] ext_sync_q;
   logic             ext_prev_q;
   logic             ext_cur;

   assign ext_mode = (speed == SPD_EXT);
   assign half_lim = (CNT_W'(HALF_BASE) << speed) - CNT_W'(1);

   // internal divider: toggles the bit clock every half period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b1;
      end else if (!run || ext_mode) begin
         cnt_q  <= '0;
         sclk_q <= 1'b1;
      end else if (cnt_q == half_lim) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign int_tick = run && !ext_mode && (cnt_q == half_lim);

   // external clock synchroniser, length chosen by parameter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_sync_q <= '1;
         ext_prev_q <= 1'b1;
      end else begin
         ext_sync_q <= {ext_sync_q[CLK_SYNC-2:0], sclk_ext};
         ext_prev_q <= ext_sync_q[CLK_SYNC-1];
      end
   end
   assign ext_cur = ext_sync_q[CLK_SYNC-1];

   assign sclk_int = sclk_q;
   assign fall_p   = ext_mode ? (run && ext_prev_q && !ext_cur) : (int_tick && sclk_q);
   assign rise_p   = ext_mode ? (run && !ext_prev_q && ext_cur) : (int_tick && !sclk_q);
endmodule

// File: rtl/hdx_shift_engine.sv
module hdx_shift_engine #(
   parameter int DATA_W   = 8,
   parameter bit SDI_SYNC = 1'b1,
   localparam int CNT_BW  = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tx_mode,
   input  logic              fall_p,
   input  logic              rise_p,
   input  logic              sdi,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] shreg,
   output logic              sdo,
   output logic              done,
   output logic [CNT_BW-1:0] bit_cnt
);
   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end

   logic              sdi_s;
   logic [DATA_W-1:0] sh_q;
   logic [CNT_BW-1:0] cnt_q;
   logic              sdo_q;
   logic              fill_bit;

   // input synchroniser variant picked by parameter
   if (SDI_SYNC) begin : g_sdi_sync
      logic [1:0] sdi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sdi_q <= '0;
         else        sdi_q <= {sdi_q[0], sdi};
      end
      assign sdi_s = sdi_q[1];
   end else begin : g_sdi_direct
      assign sdi_s = sdi;
   end

   assign fill_bit = tx_mode ? 1'b0 : sdi_s;
   assign done     = active && rise_p && (cnt_q == CNT_BW'(DATA_W - 1));

   // single shared register: host load wins over a shift in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_data;
      end else if (active && rise_p) begin
         sh_q <= {fill_bit, sh_q[DATA_W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active || done) begin
         cnt_q <= '0;
      end else if (rise_p) begin
         cnt_q <= cnt_q + CNT_BW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo_q <= 1'b1;
      end else if (active && tx_mode && fall_p) begin
         sdo_q <= sh_q[0];
      end
   end

   assign shreg   = sh_q;
   assign sdo     = sdo_q;
   assign bit_cnt = cnt_q;
endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port
   import hdx_serial_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_BASE = 20,
   parameter int CLK_SYNC = 2,
   parameter bit SDI_SYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq,
   output logic              sclk_out,
   input  logic              sclk_in,
   output logic              sdo,
   input  logic              sdi
);
   localparam int CNT_BW = $clog2(DATA_W + 1);

   if (DATA_W < CTRL_W) begin : g_bad_bus
      $error("DATA_W must be at least the control width");
   end

   ctrl_t             ctrl_q;
   logic              busy;
   logic              wr_ctrl;
   logic              data_acc;
   logic              fall_p;
   logic              rise_p;
   logic              done;
   logic [DATA_W-1:0] shreg;
   logic [CNT_BW-1:0] bit_cnt;
   logic [CTRL_W-1:0] wbits;
   logic              unused_wbus;

   assign busy     = ctrl_q.tx_go | ctrl_q.rx_go;
   assign wr_ctrl  = host_wr && !host_addr;
   assign data_acc = (host_wr || host_rd) && host_addr;
   assign wbits    = host_wdata[CTRL_W-1:0];
   assign unused_wbus = ^host_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.irq_en <= wbits[BIT_IE];
            ctrl_q.spd    <= wbits[SPD_W-1:0];
            if (!busy) begin
               ctrl_q.tx_go <= wbits[BIT_TX];
               ctrl_q.rx_go <= wbits[BIT_RX] & ~wbits[BIT_TX];
            end
         end
         if (done) begin
            ctrl_q.tx_go <= 1'b0;
            ctrl_q.rx_go <= 1'b0;
            ctrl_q.end_f <= 1'b1;
         end else if (data_acc) begin
            ctrl_q.end_f <= 1'b0;
         end
      end
   end

   hdx_clk_gen #(
      .DIV_BASE (DIV_BASE),
      .CLK_SYNC (CLK_SYNC)
   ) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .speed    (ctrl_q.spd),
      .sclk_ext (sclk_in),
      .sclk_int (sclk_out),
      .fall_p   (fall_p),
      .rise_p   (rise_p)
   );

   hdx_shift_engine #(
      .DATA_W   (DATA_W),
      .SDI_SYNC (SDI_SYNC)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (busy),
      .tx_mode   (ctrl_q.tx_go),
      .fall_p    (fall_p),
      .rise_p    (rise_p),
      .sdi       (sdi),
      .load      (host_wr && host_addr),
      .load_data (host_wdata),
      .shreg     (shreg),
      .sdo       (sdo),
      .done      (done),
      .bit_cnt   (bit_cnt)
   );

   assign host_rdata = host_addr ? shreg : DATA_W'(ctrl_q);
   assign irq        = ctrl_q.end_f & ctrl_q.irq_en;
endmodule

// File: rtl/hdx_serial_port_chk.sv
module hdx_serial_port_chk
   import hdx_serial_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_BW = $clog2(DATA_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              tx_go,
   input logic              rx_go,
   input logic              end_f,
   input logic [SPD_W-1:0]  spd,
   input logic              sclk_out,
   input logic              sdo,
   input logic              fall_p,
   input logic [CNT_BW-1:0] bit_cnt
);
   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_go && rx_go)); // R9
   AST_END_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_f) |-> $past(busy)); // R4
   AST_BUSY_ENDS_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> end_f); // R4
   AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt < CNT_BW'(DATA_W)); // R4
   AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk_out); // R7
   AST_EXT_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (spd == SPD_EXT && $past(spd) == SPD_EXT) |-> sclk_out); // R8
   AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $past(fall_p)); // R2
endmodule

bind hdx_serial_port hdx_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .tx_go    (ctrl_q.tx_go),
   .rx_go    (ctrl_q.rx_go),
   .end_f    (ctrl_q.end_f),
   .spd      (ctrl_q.spd),
   .sclk_out (sclk_out),
   .sdo      (sdo),
   .fall_p   (fall_p),
   .bit_cnt  (bit_cnt)
);

// File: tb/hdx_serial_port_bench.sv
module hdx_serial_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic       host_addr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       irq;
   logic       sclk_out;
   logic       sclk_in = 1'b1;
   logic       sdo;
   logic       sdi = 1'b0;

   int checks = 0;
   int errors = 0;
   longint cyc = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hdx_serial_port u_hdx_serial_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .irq        (irq),
      .sclk_out   (sclk_out),
      .sclk_in    (sclk_in),
      .sdo        (sdo),
      .sdi        (sdi)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wait_done(input string req);
      logic [7:0] c;
      bit seen = 0;
      for (int k = 0; k < 20000 && !seen; k++) begin
         host_read(1'b0, c);
         seen = c[7];
      end
      check(req, "end flag reached", 32'(seen), 32'd1);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      host_read(1'b0, v); check("R1", "ctrl reset", 32'(v), 32'h00);
      host_read(1'b1, v); check("R1", "data reset", 32'(v), 32'h00);
      check("R1", "sclk_out reset", 32'(sclk_out), 32'd1);
      check("R1", "sdo reset", 32'(sdo), 32'd1);
      check("R1", "irq reset", 32'(irq), 32'd0);
   endtask

   task automatic t_tx;
      logic [7:0] got, v;
      host_write(1'b1, 8'hB4);
      host_write(1'b0, 8'h10);
      for (int i = 0; i < 8; i++) begin
         @(posedge sclk_out); #1 got[i] = sdo;
         if (i == 2) begin
            host_write(1'b0, 8'h20);  // R4: enable change while busy
            host_read(1'b0, v);
            check("R4", "enables kept while busy", 32'(v[5:4]), 32'h1);
         end
      end
      check("R2", "tx bits lsb first", 32'(got), 32'hB4);
      wait_done("R4");
      host_read(1'b0, v);
      check("R4", "start bits self-cleared", 32'(v[5:4]), 32'h0);
      check("R4", "end flag set", 32'(v[7]), 32'd1);
      host_read(1'b1, v);
      check("R2", "data zero after tx", 32'(v), 32'h00);
      host_read(1'b0, v);
      check("R5", "end flag cleared by data read", 32'(v[7]), 32'd0);
   endtask

   task automatic t_rx;
      logic [7:0] v;
      logic [7:0] b = 8'h5A;
      host_write(1'b1, 8'hFF);
      host_write(1'b0, 8'h20);
      for (int i = 0; i < 8; i++) begin
         @(negedge sclk_out); #1 sdi = b[i];
         if (i == 4) begin
            host_read(1'b1, v);
            check("R11", "partial read", 32'(v), 32'({b[3:0], 4'hF}));
         end
      end
      wait_done("R3");
      check("R6", "irq low without enable", 32'(irq), 32'd0);
      host_read(1'b0, v);
      check("R5", "ctrl read keeps flag", 32'(v[7]), 32'd1);
      host_read(1'b1, v);
      check("R3", "rx byte", 32'(v), 32'h5A);
      host_read(1'b0, v);
      check("R5", "flag cleared after data read", 32'(v[7]), 32'd0);
   endtask

   task automatic t_irq;
      host_write(1'b1, 8'h00);
      host_write(1'b0, 8'h50);
      wait_done("R6");
      #1 check("R6", "irq with enable and flag", 32'(irq), 32'd1);
      host_write(1'b1, 8'h33);
      #1 check("R5", "irq cleared by data write", 32'(irq), 32'd0);
      host_write(1'b0, 8'h00);
   endtask

   task automatic t_priority;
      logic [7:0] got, v;
      host_write(1'b1, 8'hC3);
      host_write(1'b0, 8'h30);
      host_read(1'b0, v);
      check("R9", "rx bit dropped", 32'(v[5:4]), 32'h1);
      for (int i = 0; i < 8; i++) begin
         @(posedge sclk_out); #1 got[i] = sdo;
      end
      check("R9", "tx ran", 32'(got), 32'hC3);
      wait_done("R9");
      host_read(1'b1, v);
   endtask

   task automatic t_overwrite;
      logic [7:0] got, v;
      host_write(1'b1, 8'hFF);
      host_write(1'b0, 8'h10);
      for (int i = 0; i < 8; i++) begin
         @(posedge sclk_out); #1 got[i] = sdo;
         if (i == 3) host_write(1'b1, 8'hA5);
      end
      check("R10", "bits after overwrite", 32'(got), 32'h5F);
      wait_done("R10");
      host_read(1'b1, v);
      check("R10", "residue after overwrite", 32'(v), 32'h0A);
   endtask

   task automatic t_rate;
      logic [7:0] v;
      longint c0, c1;
      for (int n = 0; n < 7; n++) begin
         host_write(1'b1, 8'h00);
         host_write(1'b0, 8'(8'h10 | n));
         @(negedge sclk_out); c0 = cyc;
         @(negedge sclk_out); c1 = cyc;
         check("R7", $sformatf("period speed %0d", n), 32'(c1 - c0), 32'(20 << n));
         wait_done("R7");
         host_read(1'b1, v);
         check("R7", "idle high", 32'(sclk_out), 32'd1);
      end
   endtask

   task automatic t_ext;
      logic [7:0] v;
      logic [7:0] b = 8'h3C;
      bit quiet = 1;
      host_write(1'b0, 8'h27);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); sclk_in = 1'b0; sdi = b[i];
         repeat (8) begin @(negedge clk); if (!sclk_out) quiet = 0; end
         sclk_in = 1'b1;
         repeat (8) begin @(negedge clk); if (!sclk_out) quiet = 0; end
      end
      check("R8", "sclk_out quiet", 32'(quiet), 32'd1);
      wait_done("R8");
      host_read(1'b1, v);
      check("R8", "ext rx byte", 32'(v), 32'h3C);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_tx;
      t_rx;
      t_irq;
      t_priority;
      t_overwrite;
      t_rate;
      t_ext;
      summary;
   end

   initial begin
      #(4 * 190000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary;
   end
endmodule